// File: doc/BRIEF.md
# Logarithmic PCM Word Codec

This block converts between 14-bit two's-complement linear samples and 8-bit companded PCM words. Either the mu-law or the A-law curve can be chosen. Both directions run in parallel on every enable pulse. The encode path turns `lin_in` into a word on `pcm_out`. The decode path turns `pcm_in` into a linear value on `lin_out`. Each path is combinational logic followed by one output register.

Every word has three fields: a sign bit, a three-bit chord (segment) number and a four-bit step number. A selectable line code is then applied to the word:
- plain sign-magnitude;
- true sign with all magnitude bits inverted;
- inversion of every even-numbered bit.

On decode the line code is removed first. The decoder then returns the midpoint of the linear interval that the word stands for, so re-encoding that value gives back the same word.

Both curves share one linear grid, with full scale at magnitude 8192. The A-law top decision level falls on full scale. The mu-law top level sits 33 units lower, which gives the slightly earlier mu-law overload.

Top module: `lpcm_codec`

## Requirements
- R1: Word layout is bit 7 = sign, bits 6..4 = chord (0-7), bits 3..0 = step (0-15). In the un-coded word the sign bit is 1 for a non-negative input (zero included) and 0 for a negative input.
- R2: Mu-law encode uses magnitude m = |lin_in| and b = min(m, 8158) + 33. The chord is (index of the highest set bit of b) - 5, and the step is (b >> (chord+1)) mod 16.
- R3: A-law encode uses m = min(|lin_in|, 8191). If m < 64, the chord is 0 and the step is m >> 2. Otherwise the chord is (index of the highest set bit of m) - 5 and the step is (m >> (chord+1)) mod 16.
- R4: Inputs beyond the overload point, including -8192, saturate to chord 7, step 15. With fmt_sel = 0, lin_in = -8192 yields 8'h7F.
- R5: fmt_sel selects the line code, applied on encode and removed on decode. Value 0 means no inversion. Value 1 XORs the word with 8'h7F. Value 2 XORs it with 8'h55. Value 3 behaves as 0.
- R6: Mu-law decode magnitude is (33 + 2·step)·2^chord − 33.
- R7: A-law decode magnitude is 2 + 4·step for chord 0, and (33 + 2·step)·2^chord for chords 1-7.
- R8: A decoded word with sign bit 1 gives +magnitude on lin_out. A word with sign bit 0 gives −magnitude in 14-bit two's complement.
- R9: Encoding the decoded value of any word, under the same law and format, returns that word. The one exception is the mu-law negative-zero word, which re-encodes with sign 1.
- R10: law_sel, fmt_sel, lin_in and pcm_in are sampled on a rising clock edge where en is 1. Both outputs update at that edge. While en is 0 both outputs hold.
- R11: A synchronous active-high rst clears pcm_out and lin_out to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Conversion enable; samples all inputs |
| law_sel | input | 1 | 0 = mu-law, 1 = A-law |
| fmt_sel | input | 2 | Line code select (0 plain, 1 inverted magnitude, 2 even-bit inversion, 3 as 0) |
| lin_in | input | 14 | Linear sample to encode, two's complement |
| pcm_in | input | 8 | Line-coded PCM word to decode |
| pcm_out | output | 8 | Registered line-coded PCM word |
| lin_out | output | 14 | Registered decoded linear value, two's complement |

## Verification
The decoder is exercised with every one of the 256 words under both laws and all four format codes. This exhaustive sweep separates:
- the chord-0 special case of A-law from the mu-law bias;
- each line code from the others.

The encoder is swept across the full linear range in coarse strides. It is also driven with chord edges, the ±33 bias region, the overload points and -8192. These inputs expose off-by-one thresholds and saturation faults.

A loop-back pass feeds each decoded value back into the encoder. It shows that every decoded level lies inside its own decision interval. Idle cycles with changing inputs show that the outputs hold when enable is low.

// File: rtl/lpcm_pkg.sv
package lpcm_pkg;

    localparam int LIN_W      = 14;
    localparam int MAG_W      = LIN_W + 1;
    localparam int PCM_W      = 8;
    localparam int CHORD_W    = 3;
    localparam int STEP_W     = 4;
    localparam int BASE_BIT   = LIN_W - 9;                 // highest bit index of chord 0 span
    localparam int MAG_MAX    = (1 << (LIN_W - 1)) - 1;    // largest encodable magnitude
    localparam int MU_BIAS    = 33;
    localparam int MU_CLIP    = MAG_MAX - MU_BIAS;
    localparam int A_SEG_EDGE = 1 << (BASE_BIT + 1);        // end of A-law linear segment

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    typedef enum logic [1:0] {
        FMT_PLAIN   = 2'd0,
        FMT_INV_MAG = 2'd1,
        FMT_ALT_BIT = 2'd2,
        FMT_SPARE   = 2'd3
    } fmt_e;

    typedef struct packed {
        logic                 sign;
        logic [CHORD_W-1:0]   chord;
        logic [STEP_W-1:0]    step;
    } pcm_t;

    // XOR pattern applied to the sign-magnitude word for each line code
    function automatic logic [PCM_W-1:0] line_mask(fmt_e f);
        case (f)
            FMT_INV_MAG: line_mask = 8'h7F;
            FMT_ALT_BIT: line_mask = 8'h55;
            default:     line_mask = 8'h00;
        endcase
    endfunction

    // index of the most significant set bit (0 when no bit is set)
    function automatic logic [3:0] lead_one(logic [MAG_W-1:0] v);
        lead_one = '0;
        for (int i = 0; i < MAG_W; i++) begin
            if (v[i]) lead_one = 4'(i);
        end
    endfunction

endpackage

// File: rtl/lpcm_encoder.sv
module lpcm_encoder
    import lpcm_pkg::*;
(
    input  law_e                    law,
    input  logic [LIN_W-1:0]        lin,
    output pcm_t                    fields
);

    logic [MAG_W-1:0] mag;
    logic [MAG_W-1:0] biased;
    logic [3:0]       lead;
    logic [CHORD_W-1:0] chord;
    logic [MAG_W-1:0] shifted;

    always_comb begin
        mag = lin[LIN_W-1] ? (MAG_W'(0) - {lin[LIN_W-1], lin}) : {1'b0, lin};

        if (law == LAW_MU) begin
            biased = (mag > MAG_W'(MU_CLIP)) ? MAG_W'(MU_CLIP) : mag;
            biased = biased + MAG_W'(MU_BIAS);
        end else begin
            biased = (mag > MAG_W'(MAG_MAX)) ? MAG_W'(MAG_MAX) : mag;
        end

        lead = lead_one(biased);

        if (law == LAW_A && biased < MAG_W'(A_SEG_EDGE)) begin
            chord   = '0;
            shifted = biased >> 2;
        end else begin
            chord   = CHORD_W'(lead - 4'(BASE_BIT));
            shifted = biased >> (32'(chord) + 1);
        end

        fields.sign  = ~lin[LIN_W-1];
        fields.chord = chord;
        fields.step  = shifted[STEP_W-1:0];
    end

endmodule

// File: rtl/lpcm_decoder.sv
module lpcm_decoder
    import lpcm_pkg::*;
(
    input  law_e                    law,
    input  pcm_t                    fields,
    output logic [LIN_W-1:0]        lin
);

    logic [MAG_W-1:0] seg_level;
    logic [MAG_W-1:0] scaled;
    logic [MAG_W-1:0] mag;

    always_comb begin
        seg_level = MAG_W'(MU_BIAS) + MAG_W'({fields.step, 1'b0});
        scaled    = seg_level << fields.chord;

        if (law == LAW_MU) begin
            mag = scaled - MAG_W'(MU_BIAS);
        end else if (fields.chord == '0) begin
            mag = MAG_W'({fields.step, 2'b10});
        end else begin
            mag = scaled;
        end

        lin = fields.sign ? mag[LIN_W-1:0] : LIN_W'(MAG_W'(0) - mag);
    end

endmodule

// File: rtl/lpcm_codec.sv
module lpcm_codec
    import lpcm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        law_sel,
    input  logic [1:0]  fmt_sel,
    input  logic [13:0] lin_in,
    input  logic [7:0]  pcm_in,
    output logic [7:0]  pcm_out,
    output logic [13:0] lin_out
);

    law_e             law;
    fmt_e             fmt;
    logic [PCM_W-1:0] mask;
    pcm_t             enc_fields;
    pcm_t             dec_fields;
    logic [LIN_W-1:0] dec_lin;

    assign law        = law_e'(law_sel);
    assign fmt        = fmt_e'(fmt_sel);
    assign mask       = line_mask(fmt);
    assign dec_fields = pcm_t'(pcm_in ^ mask);

    lpcm_encoder u_enc (
        .law    (law),
        .lin    (lin_in),
        .fields (enc_fields)
    );

    lpcm_decoder u_dec (
        .law    (law),
        .fields (dec_fields),
        .lin    (dec_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pcm_out <= '0;
            lin_out <= '0;
        end else if (en) begin
            pcm_out <= PCM_W'(enc_fields) ^ mask;
            lin_out <= dec_lin;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(pcm_out) && $stable(lin_out)); // R10
    AST_SIGN_POS: assert property (@(posedge clk) disable iff (rst) en && !lin_in[13] |=> pcm_out[7]); // R1
    AST_SIGN_NEG: assert property (@(posedge clk) disable iff (rst) en && lin_in[13] |=> !pcm_out[7]); // R1
    AST_OVERLOAD: assert property (@(posedge clk) disable iff (rst) en && fmt_sel == 2'd0 && lin_in == 14'h2000 |=> pcm_out == 8'h7F); // R4
    AST_DEC_NONNEG: assert property (@(posedge clk) disable iff (rst) en && pcm_in[7] |=> !lin_out[13]); // R8
    AST_DEC_NONPOS: assert property (@(posedge clk) disable iff (rst) en && !pcm_in[7] |=> lin_out[13] || lin_out == 14'd0); // R8
    AST_A_NONZERO: assert property (@(posedge clk) disable iff (rst) en && law_sel |=> lin_out != 14'd0); // R7

endmodule

// File: tb/tb_lpcm_codec.sv
module tb_lpcm_codec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        law_sel = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [13:0] lin_in = '0;
    logic [7:0]  pcm_in = '0;
    logic [7:0]  pcm_out;
    logic [13:0] lin_out;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    int exp_pcm = 0;
    int exp_lin = 0;
    string tag = "R11";

    always #2 clk = ~clk;

    lpcm_codec dut (
        .clk(clk), .rst(rst), .en(en), .law_sel(law_sel), .fmt_sel(fmt_sel),
        .lin_in(lin_in), .pcm_in(pcm_in), .pcm_out(pcm_out), .lin_out(lin_out)
    );

    function automatic int apply_code(int w, int fmt);
        if (fmt == 1) return w ^ 127;
        if (fmt == 2) return w ^ 85;
        return w;
    endfunction

    function automatic int ref_encode(int x, int law, int fmt);
        int m, c, s;
        m = (x < 0) ? -x : x;
        c = 0;
        if (law == 0) begin
            if (m > 8158) m = 8158;
            m = m + 33;
            for (int k = 1; k < 8; k++) if (m >= (32 << k)) c = k;
            s = (m - (32 << c)) / (2 << c);
        end else begin
            if (m > 8191) m = 8191;
            if (m < 64) s = m / 4;
            else begin
                c = 1;
                for (int k = 2; k < 8; k++) if (m >= (32 << k)) c = k;
                s = (m - (32 << c)) / (2 << c);
            end
        end
        return apply_code(((x >= 0) ? 128 : 0) + c * 16 + s, fmt);
    endfunction

    function automatic int ref_decode(int w, int law, int fmt);
        int raw, c, s, m;
        raw = apply_code(w, fmt);
        c = (raw / 16) % 8;
        s = raw % 16;
        if (law == 0) m = (33 + 2 * s) * (1 << c) - 33;
        else if (c == 0) m = 2 + 4 * s;
        else m = (33 + 2 * s) * (1 << c);
        return (raw >= 128) ? m : -m;
    endfunction

    task automatic compare_outputs();
        compared++;
        if (int'(pcm_out) != exp_pcm) begin
            mismatched++;
            $display("FAIL %s pcm_out actual=%02h expected=%02h", tag, pcm_out, exp_pcm[7:0]);
        end
        compared++;
        if (int'($signed(lin_out)) != exp_lin) begin
            mismatched++;
            $display("FAIL %s lin_out actual=%0d expected=%0d", tag, $signed(lin_out), exp_lin);
        end
    endtask

    // drive at negedge, clock once, check at next negedge
    task automatic step(bit e, int law, int fmt, int li, int pw);
        en = e;
        law_sel = law[0];
        fmt_sel = fmt[1:0];
        lin_in = 14'(li);
        pcm_in = 8'(pw);
        if (e) begin
            exp_pcm = ref_encode(li, law, (fmt == 3) ? 0 : fmt);
            exp_lin = ref_decode(pw, law, (fmt == 3) ? 0 : fmt);
        end
        @(posedge clk);
        @(negedge clk);
        compare_outputs();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int bounds[20];
        bounds = '{0, -1, 1, 31, 32, 33, -33, 63, 64, 65, -64, 95, 96, 8158, 8159,
                   8191, -8191, -8192, 4095, -4096};

        // R11: reset clears outputs
        repeat (3) @(negedge clk);
        tag = "R11";
        exp_pcm = 0;
        exp_lin = 0;
        compare_outputs();
        rst = 1'b0;

        // R6 R7 R8 R5: every word, both laws, all line codes
        for (int law = 0; law < 2; law++) begin
            for (int fmt = 0; fmt < 4; fmt++) begin
                tag = (law == 0) ? "R6 R8 R5 R10" : "R7 R8 R5 R10";
                for (int w = 0; w < 256; w++) step(1'b1, law, fmt, (w * 37) - 4000, w);
            end
        end

        // R2 R3 R1 R5: coarse sweep of the linear range
        for (int law = 0; law < 2; law++) begin
            for (int fmt = 0; fmt < 4; fmt++) begin
                tag = (law == 0) ? "R2 R1 R5" : "R3 R1 R5";
                for (int x = -8192; x < 8192; x += 53) step(1'b1, law, fmt, x, x & 255);
            end
        end

        // R4 R2 R3: chord edges, bias region, overload
        tag = "R4 R2 R3";
        for (int law = 0; law < 2; law++)
            for (int fmt = 0; fmt < 3; fmt++)
                foreach (bounds[i]) step(1'b1, law, fmt, bounds[i], 0);
        tag = "R4";
        step(1'b1, 0, 0, -8192, 0);
        step(1'b1, 1, 0, -8192, 0);
        step(1'b1, 1, 0, 8191, 0);

        // R10: idle cycles with moving inputs leave outputs unchanged
        tag = "R10";
        step(1'b1, 1, 2, 1234, 8'h3C);
        for (int k = 0; k < 20; k++) step(1'b0, k % 2, k % 4, k * 401 - 3000, k * 13);

        // R9: decoded value looped back into the encoder
        for (int law = 0; law < 2; law++) begin
            for (int fmt = 0; fmt < 3; fmt++) begin
                tag = "R9";
                step(1'b1, law, fmt, 0, 0);
                for (int w = 1; w <= 256; w++) begin
                    step(1'b1, law, fmt, int'($signed(lin_out)), w & 255);
                    if (!(law == 0 && apply_code(w - 1, fmt) == 0)) begin
                        compared++;
                        if (int'(pcm_out) != w - 1) begin
                            mismatched++;
                            $display("FAIL R9 loopback actual=%02h expected=%02h", pcm_out, 8'(w - 1));
                        end
                    end
                end
            end
        end

        // R11: reset mid-run
        tag = "R11";
        rst = 1'b1;
        en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        exp_pcm = 0;
        exp_lin = 0;
        compare_outputs();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule